// File: doc/BRIEF.md
# Edge-Gated Median Pixel Filter

This block cleans up isolated one-pixel defects that remain along object outlines after anti-aliasing. It receives a stream of RGB pixels, one per clock, with a start-of-line and an end-of-line marker. Each pixel carries a coverage code that tells whether it lies fully inside a surface or on a silhouette edge. For every pixel the filter looks at a three-tap horizontal window: the left neighbour, the pixel itself and the right neighbour.

When any of the three taps is an edge pixel, the output replaces the centre with the median of the three taps. The median is taken separately for red, green and blue. When all three taps are fully covered, the centre passes through untouched, so surface texture is never softened. A per-pixel enable turns the filter off, and the pixel then passes straight through. At either end of a line, the missing neighbour is replaced by a copy of the centre. Pixels from an adjacent line never enter the window.

Top module: `edge_median_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `out_valid` is 0 and `out_pix` is 0.
- R2: A pixel presented with `in_valid` high in cycle t appears on `out_pix` with `out_valid` high in cycle t+2. Outputs keep the input order, and there is exactly one output per input pixel.
- R3: Pixels are packed as red in bits [23:16], green in bits [15:8] and blue in bits [7:0]. A filtered output channel is the median of the left, centre and right values of that same channel, computed independently for each channel.
- R4: A coverage code of 7 marks an interior pixel. Any other code, 6 included, marks an edge pixel. Filtering applies when the centre or either real neighbour is an edge pixel.
- R5: When the centre and both neighbours have coverage 7, the output equals the centre pixel exactly.
- R6: The enable is sampled together with each pixel. A pixel sent with `filt_en` at 0 comes out unchanged, whatever the coverage of its window.
- R7: For a pixel sent with `in_sol` high, the left tap is a copy of the centre. The last pixel of the previous line has no effect on it.
- R8: For a pixel sent with `in_eol` high, the right tap is a copy of the centre. A one-pixel line (`in_sol` and `in_eol` both high) therefore comes out unchanged.
- R9: Within a line, `in_valid` stays high from the start pixel through the end pixel. Idle cycles are allowed only between lines. A new line may follow an end pixel in the very next cycle, and no pixel crosses the line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_en | input | 1 | Filter enable, sampled with each pixel |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| in_pix | input | 24 | Input pixel, R[23:16] G[15:8] B[7:0] |
| in_cov | input | 3 | Coverage code, 7 = full |
| out_valid | output | 1 | Output pixel present this cycle |
| out_pix | output | 24 | Filtered or passed-through pixel |

## Verification
Every result is due exactly two cycles after its pixel is presented. The right neighbour is taken from the live input in the cycle after the centre arrives, and the result is registered on that same edge. The driver stamps each expected pixel with the cycle count at presentation plus two. The monitor compares both the pixel value and the arrival cycle when `out_valid` rises. Back-to-back lines with edge pixels at their joins show that neither boundary leaks a neighbour into the other line.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int CH_W     = 8;
    localparam int N_CH     = 3;
    localparam int COV_W    = 3;
    localparam int PIX_W    = CH_W * N_CH;
    localparam logic [COV_W-1:0] COV_FULL = {COV_W{1'b1}};

    typedef logic [CH_W-1:0]  chan_t;
    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [COV_W-1:0] cov_t;

    // one tap of the window: colour plus coverage
    typedef struct packed {
        pix_t pix;
        cov_t cov;
    } tap_t;

    // a tap with its line markers and the enable captured alongside it
    typedef struct packed {
        tap_t tap;
        logic sol;
        logic eol;
        logic en;
    } stage_t;

    // how the output pixel is chosen
    typedef enum logic [1:0] {
        SEL_BYPASS  = 2'd0,
        SEL_SURFACE = 2'd1,
        SEL_MEDIAN  = 2'd2
    } sel_e;

    function automatic logic is_edge(input cov_t c);
        return c != COV_FULL;
    endfunction

    function automatic chan_t chan_of(input pix_t p, input int idx);
        return p[idx*CH_W +: CH_W];
    endfunction

endpackage

// File: rtl/pf_med3_lane.sv
module pf_med3_lane
    import pf_pkg::*;
(
    input  chan_t a,
    input  chan_t b,
    input  chan_t c,
    output chan_t m
);
    chan_t lo_ab;
    chan_t hi_ab;
    chan_t hi_c;

    always_comb begin
        lo_ab = (a < b) ? a : b;
        hi_ab = (a < b) ? b : a;
        hi_c  = (hi_ab < c) ? hi_ab : c;
        m     = (lo_ab > hi_c) ? lo_ab : hi_c;
    end

    always_comb begin
        // R3
        med_member_chk: assert ((m == a) || (m == b) || (m == c));
        // R3
        med_range_chk: assert (((m >= a) || (m >= b)) && ((m <= a) || (m <= b)) &&
                               ((m >= b) || (m >= c)) && ((m <= b) || (m <= c)));
    end
endmodule

// File: rtl/pf_median_pix.sv
module pf_median_pix
    import pf_pkg::*;
(
    input  pix_t left,
    input  pix_t centre,
    input  pix_t right,
    output pix_t med
);
    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        chan_t lane_m;
        pf_med3_lane i_lane (
            .a (chan_of(left, g)),
            .b (chan_of(centre, g)),
            .c (chan_of(right, g)),
            .m (lane_m)
        );
        assign med[g*CH_W +: CH_W] = lane_m;
    end
endmodule

// File: rtl/pf_window.sv
module pf_window
    import pf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  stage_t in_stage,
    output logic   cen_vld,
    output stage_t cen,
    output tap_t   left,
    output tap_t   right
);
    stage_t s1_q;
    logic   s1_vld_q;
    tap_t   s0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= '0;
            s1_vld_q <= 1'b0;
            s0_q     <= '0;
        end else begin
            s1_vld_q <= in_valid;
            if (in_valid) begin
                s0_q <= s1_q.tap;
                s1_q <= in_stage;
            end
        end
    end

    always_comb begin
        cen_vld = s1_vld_q;
        cen     = s1_q;
        left    = s1_q.sol ? s1_q.tap : s0_q;
        right   = s1_q.eol ? s1_q.tap : in_stage.tap;
    end

    // R9
    line_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_vld_q && !s1_q.eol) |-> in_valid);

    // R9
    line_open_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_vld_q && !s1_q.eol && in_valid) |-> !in_stage.sol);
endmodule

// File: rtl/edge_median_filter.sv
module edge_median_filter
    import pf_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            filt_en,
    input  logic                            in_valid,
    input  logic                            in_sol,
    input  logic                            in_eol,
    input  logic [pf_pkg::PIX_W-1:0]        in_pix,
    input  logic [pf_pkg::COV_W-1:0]        in_cov,
    output logic                            out_valid,
    output logic [pf_pkg::PIX_W-1:0]        out_pix
);
    stage_t in_stage;
    stage_t cen;
    tap_t   left;
    tap_t   right;
    logic   cen_vld;
    pix_t   med;
    logic   edge_any;
    sel_e   sel;
    logic   out_vld_q;
    pix_t   out_pix_q;

    always_comb begin
        in_stage.tap.pix = in_pix;
        in_stage.tap.cov = in_cov;
        in_stage.sol     = in_sol;
        in_stage.eol     = in_eol;
        in_stage.en      = filt_en;
    end

    pf_window i_window (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_stage (in_stage),
        .cen_vld  (cen_vld),
        .cen      (cen),
        .left     (left),
        .right    (right)
    );

    pf_median_pix i_median (
        .left   (left.pix),
        .centre (cen.tap.pix),
        .right  (right.pix),
        .med    (med)
    );

    always_comb begin
        edge_any = is_edge(left.cov) || is_edge(cen.tap.cov) || is_edge(right.cov);
        if (!cen.en)
            sel = SEL_BYPASS;
        else if (!edge_any)
            sel = SEL_SURFACE;
        else
            sel = SEL_MEDIAN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_q <= 1'b0;
            out_pix_q <= '0;
        end else begin
            out_vld_q <= cen_vld;
            if (cen_vld)
                out_pix_q <= (sel == SEL_MEDIAN) ? med : cen.tap.pix;
        end
    end

    assign out_valid = out_vld_q;
    assign out_pix   = out_pix_q;

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (cen_vld && !cen.en) |=> (out_pix == $past(cen.tap.pix)));

    // R5
    surface_chk: assert property (@(posedge clk) disable iff (rst)
        (cen_vld && !is_edge(left.cov) && !is_edge(cen.tap.cov) && !is_edge(right.cov))
        |=> (out_pix == $past(cen.tap.pix)));

    // R2
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !cen_vld |=> $stable(out_pix));
endmodule

// File: tb/test_edge_median_filter.sv
`timescale 1ns/1ps
module test_edge_median_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        filt_en;
    logic        in_valid;
    logic        in_sol;
    logic        in_eol;
    logic [23:0] in_pix;
    logic [2:0]  in_cov;
    logic        out_valid;
    logic [23:0] out_pix;

    always #4 clk = ~clk;

    edge_median_filter i_edge_median_filter (
        .clk       (clk),
        .rst       (rst),
        .filt_en   (filt_en),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .in_pix    (in_pix),
        .in_cov    (in_cov),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    typedef struct {
        logic [23:0] pix;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc   = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] chan_val(input int seed, input int i, input int ch);
        return 8'((i * 73 + seed * 29 + ch * 101) ^ (i * i * 7 + ch * 13 + seed));
    endfunction

    function automatic logic [2:0] cov_val(input int mode, input int i, input int n);
        case (mode)
            1: return (i == n / 2) ? 3'd3 : 3'd7;
            2: return (i == 0) ? 3'd6 : 3'd7;
            3: return (i == n - 1) ? 3'd0 : 3'd7;
            4: return (i % 3 == 0) ? 3'd5 : 3'd7;
            5: return (i == 2) ? 3'd6 : 3'd7;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [7:0] med3(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c);
        if ((a >= b && a <= c) || (a <= b && a >= c)) return a;
        if ((b >= a && b <= c) || (b <= a && b >= c)) return b;
        return c;
    endfunction

    task automatic send_line(input int n, input int seed, input int mode, input bit en,
                             input int gap, input string tag);
        logic [23:0] p[16];
        logic [2:0]  c[16];
        for (int i = 0; i < n; i++) begin
            p[i] = {chan_val(seed, i, 2), chan_val(seed, i, 1), chan_val(seed, i, 0)};
            c[i] = cov_val(mode, i, n);
        end
        for (int i = 0; i < n; i++) begin
            logic [23:0] lp;
            logic [23:0] rp;
            logic [23:0] e;
            bit          eg;
            lp = (i == 0) ? p[i] : p[i-1];
            rp = (i == n - 1) ? p[i] : p[i+1];
            eg = (c[i] != 3'd7) || (i > 0 && c[i-1] != 3'd7) || (i < n - 1 && c[i+1] != 3'd7);
            if (en && eg)
                e = {med3(lp[23:16], p[i][23:16], rp[23:16]),
                     med3(lp[15:8],  p[i][15:8],  rp[15:8]),
                     med3(lp[7:0],   p[i][7:0],   rp[7:0])};
            else
                e = p[i];
            @(negedge clk);
            in_valid = 1'b1;
            in_sol   = (i == 0);
            in_eol   = (i == n - 1);
            in_pix   = p[i];
            in_cov   = c[i];
            filt_en  = en;
            q.push_back('{e, cyc + 2, tag});
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sol   = 1'b0;
            in_eol   = 1'b0;
            in_pix   = 24'h0;
            in_cov   = 3'd0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected output", {8'h0, out_pix}, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_pix == e.pix, e.tag, "pixel", {8'h0, out_pix}, {8'h0, e.pix});
                check(cyc == e.due, "R2", "arrival cycle", cyc, e.due);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog expired: actual %0d expected %0d", cyc, 5000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        filt_en  = 1'b0;
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_eol   = 1'b0;
        in_pix   = 24'h0;
        in_cov   = 3'd0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(out_valid == 1'b0 && out_pix == 24'h0, "R1", "reset outputs",
              {7'h0, out_valid, out_pix}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // R1 first cycle after release
        check(out_valid == 1'b0 && out_pix == 24'h0, "R1", "post-reset outputs",
              {7'h0, out_valid, out_pix}, 32'h0);

        send_line(8, 1, 0, 1'b1, 2, "R5");
        send_line(9, 2, 1, 1'b1, 2, "R3");
        send_line(7, 3, 4, 1'b1, 2, "R4");
        send_line(6, 4, 5, 1'b1, 2, "R4");
        send_line(8, 5, 4, 1'b0, 2, "R6");
        send_line(6, 6, 2, 1'b1, 1, "R7");
        send_line(6, 7, 3, 1'b1, 1, "R8");
        send_line(1, 8, 3, 1'b1, 1, "R8");
        send_line(5, 9, 3, 1'b1, 0, "R9");
        send_line(5, 10, 2, 1'b1, 0, "R9");
        send_line(4, 11, 1, 1'b1, 3, "R9");
        send_line(10, 12, 4, 1'b1, 4, "R3");

        repeat (6) @(negedge clk);
        check(q.size() == 0, "R2", "missing outputs", q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule